// File: doc/BRIEF.md
# Dot-Clock Display Timing Generator

This block produces the scan timing for a parallel RGB panel clocked by a dot clock. It outputs horizontal sync, vertical sync, data-enable, a one-cycle frame-start pulse, and an active-pixel request strobe. The request strobe leads data-enable by one clock, so an upstream pixel source has one cycle to present each pixel. Horizontal timing is programmed as four values: the total line length in dot clocks, the hsync width, a cumulative wait (sync width plus back porch) after which active pixels begin, and the number of active pixels. The vertical axis uses the same four values counted in lines.

All timing inputs, the three polarity selects and the launch-edge select are captured into a shadow copy at each frame boundary, so changing them mid-frame never tears a frame. A next-frame base address is handled the same way: it is presented at any time and becomes the current base address only when a new frame begins. Sync generation is enabled separately from the run request. With sync enabled and run clear, the panel receives sync only. When run is cleared, the frame already in progress completes with data before the block reports that it has stopped.

Top module: `dotclk_timing_gen`

## Requirements
- R1: During and after a synchronous active-low reset with sync disabled and all polarity selects clear, hsync, vsync and de sit high (inactive for active-low), and frame_start, running, pix_req and cur_base are all 0.
- R2: Within each line, hsync is active for dot clocks 0 to hsync width minus 1, and a line lasts exactly the programmed line length.
- R3: Within each frame, vsync is active for lines 0 to vsync width minus 1, and a frame lasts exactly the programmed number of lines.
- R4: de is active exactly when the dot position h satisfies wait <= h < wait + active pixels, the line v satisfies vertical wait <= v < vertical wait + active lines, and the frame is a running frame. A wait of zero puts the first active pixel at position 0.
- R5: pix_req is active-high and is asserted exactly one clock before each active de cycle.
- R6: Polarity selects: a set select drives hsync, vsync or de high when active, and a clear select drives it low when active. launch_fall repeats the launch-edge select of the current frame.
- R7: With sync enabled and run clear, hsync and vsync run normally while de never becomes active and running stays 0.
- R8: A frame is a running frame when run_req is set at the frame boundary that starts it. Clearing run_req mid-frame lets that frame finish with data and running high, and running drops at the next frame start.
- R9: cur_base takes the value of next_base present at the frame boundary, and it changes only in a cycle where frame_start is high.
- R10: Timing, polarity and launch-edge inputs changed mid-frame take effect only from the next frame start.
- R11: frame_start is a one-cycle pulse at line 0, dot 0. After sync_en is first sampled high at a rising edge, the outputs for that position appear after the following rising edge.
- R12: When sync_en is cleared, scanning stops: within two clocks hsync, vsync and de return to their inactive levels, and frame_start, pix_req and running are 0. Re-enabling sync starts a fresh frame at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_en | input | 1 | Enables scanning and sync generation |
| run_req | input | 1 | Requests data frames (de and pix_req) |
| cfg_h_period | input | H_W | Total line length in dot clocks |
| cfg_h_sync | input | HS_W | Hsync width in dot clocks |
| cfg_h_wait | input | HWT_W | Dot clocks from line start to first active pixel |
| cfg_h_active | input | H_W | Active pixels per line |
| cfg_v_period | input | V_W | Total frame length in lines |
| cfg_v_sync | input | VS_W | Vsync width in lines |
| cfg_v_wait | input | V_W | Lines from frame start to first active line |
| cfg_v_active | input | V_W | Active lines per frame |
| cfg_hs_high | input | 1 | Hsync active-high select |
| cfg_vs_high | input | 1 | Vsync active-high select |
| cfg_de_high | input | 1 | Data-enable active-high select |
| cfg_launch_fall | input | 1 | Select falling-edge data launch |
| next_base | input | A_W | Base address for the next frame |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_req | output | 1 | Active-pixel request, one clock ahead of de |
| frame_start | output | 1 | One-cycle pulse at the first dot of a frame |
| running | output | 1 | Current frame carries data |
| launch_fall | output | 1 | Launch-edge select in effect |
| cur_base | output | A_W | Base address of the current frame |

## Verification
The bench builds the block with narrow fields (H_W=10, HS_W=6, HWT_W=8, V_W=8, VS_W=10, A_W=16) and registered outputs. These widths keep every frame down to a few dozen dot clocks, so each scan position of every frame can be predicted and compared cycle by cycle. That makes a mid-frame change of timing, run and base reachable within a two-frame run, along with a zero wait whose active window covers the full line and the line/frame wrap. The vsync field is wider than the vertical counter, which exercises the mixed-width compare.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

   // Per-frame signal polarity and launch-edge selection
   typedef struct packed {
      logic launch_fall;
      logic de_high;
      logic vs_high;
      logic hs_high;
   } dtg_pol_t;

   // Pin level for an internally active-high indication
   function automatic logic level_of(input logic act, input logic high);
      return high ? act : ~act;
   endfunction

endpackage

// File: rtl/dtg_axis.sv
// One scan axis: position counter plus sync and visible-window decode
module dtg_axis #(
   parameter int CNT_W  = 18,
   parameter int SYNC_W = 14,
   parameter int WAIT_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   input  logic [CNT_W-1:0]  period,
   input  logic [SYNC_W-1:0] sync_len,
   input  logic [WAIT_W-1:0] wait_len,
   input  logic [CNT_W-1:0]  act_len,
   output logic [CNT_W-1:0]  cnt,
   output logic              last,
   output logic              at_zero,
   output logic              sync_act,
   output logic              vis_act
);
   localparam int MAX_A = (CNT_W > SYNC_W) ? CNT_W : SYNC_W;
   localparam int MAX_W = (MAX_A > WAIT_W) ? MAX_A : WAIT_W;
   localparam int CMP_W = MAX_W + 1;

   logic [CMP_W-1:0] cnt_x, per_x, sync_x, wait_x, act_x, off_x;

   always_comb begin
      cnt_x  = CMP_W'(cnt);
      per_x  = CMP_W'(period);
      sync_x = CMP_W'(sync_len);
      wait_x = CMP_W'(wait_len);
      act_x  = CMP_W'(act_len);
      off_x  = cnt_x - wait_x;
   end

   assign last     = (cnt_x + CMP_W'(1)) == per_x;
   assign at_zero  = (cnt == '0);
   assign sync_act = cnt_x < sync_x;
   assign vis_act  = (cnt_x >= wait_x) && (off_x < act_x);

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         cnt <= '0;
      else if (step)
         cnt <= last ? '0 : cnt + CNT_W'(1);
   end
endmodule

// File: rtl/dtg_shadow.sv
// Register loaded only on a boundary strobe
module dtg_shadow #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (en)
         q <= d;
   end
endmodule

// File: rtl/dtg_out_stage.sv
// Polarity application and optional output register
module dtg_out_stage
   import dtg_pkg::*;
#(
   parameter int A_W = 32,
   parameter bit REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hs_act,
   input  logic           vs_act,
   input  logic           de_act,
   input  logic           fs_act,
   input  logic           run_act,
   input  dtg_pol_t       pol,
   input  logic [A_W-1:0] base_in,
   output logic           hsync,
   output logic           vsync,
   output logic           de,
   output logic           frame_start,
   output logic           running,
   output logic           launch_fall,
   output logic [A_W-1:0] base_out
);
   logic hs_lv, vs_lv, de_lv;

   assign hs_lv = level_of(hs_act, pol.hs_high);
   assign vs_lv = level_of(vs_act, pol.vs_high);
   assign de_lv = level_of(de_act, pol.de_high);

   generate
      if (REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               hsync       <= 1'b1;
               vsync       <= 1'b1;
               de          <= 1'b1;
               frame_start <= 1'b0;
               running     <= 1'b0;
               launch_fall <= 1'b0;
               base_out    <= '0;
            end else begin
               hsync       <= hs_lv;
               vsync       <= vs_lv;
               de          <= de_lv;
               frame_start <= fs_act;
               running     <= run_act;
               launch_fall <= pol.launch_fall;
               base_out    <= base_in;
            end
         end
      end else begin : g_comb
         assign hsync       = hs_lv;
         assign vsync       = vs_lv;
         assign de          = de_lv;
         assign frame_start = fs_act;
         assign running     = run_act;
         assign launch_fall = pol.launch_fall;
         assign base_out    = base_in;
      end
   endgenerate
endmodule

// File: rtl/dotclk_timing_gen.sv
module dotclk_timing_gen
   import dtg_pkg::*;
#(
   parameter int H_W         = 18,
   parameter int HS_W        = 14,
   parameter int HWT_W       = 12,
   parameter int V_W         = 16,
   parameter int VS_W        = 18,
   parameter int A_W         = 32,
   parameter bit REG_OUTPUTS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_en,
   input  logic             run_req,
   input  logic [H_W-1:0]   cfg_h_period,
   input  logic [HS_W-1:0]  cfg_h_sync,
   input  logic [HWT_W-1:0] cfg_h_wait,
   input  logic [H_W-1:0]   cfg_h_active,
   input  logic [V_W-1:0]   cfg_v_period,
   input  logic [VS_W-1:0]  cfg_v_sync,
   input  logic [V_W-1:0]   cfg_v_wait,
   input  logic [V_W-1:0]   cfg_v_active,
   input  logic             cfg_hs_high,
   input  logic             cfg_vs_high,
   input  logic             cfg_de_high,
   input  logic             cfg_launch_fall,
   input  logic [A_W-1:0]   next_base,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic             pix_req,
   output logic             frame_start,
   output logic             running,
   output logic             launch_fall,
   output logic [A_W-1:0]   cur_base
);
   localparam int POL_W = $bits(dtg_pol_t);
   localparam int CFG_W = 2*H_W + HS_W + HWT_W + 3*V_W + VS_W + POL_W;

   generate
      if (H_W < 2)       begin : g_bad_h   $error("H_W must be at least 2");     end
      if (V_W < 2)       begin : g_bad_v   $error("V_W must be at least 2");     end
      if (HWT_W > H_W)   begin : g_bad_hwt $error("HWT_W must not exceed H_W");  end
      if (HS_W > H_W)    begin : g_bad_hs  $error("HS_W must not exceed H_W");   end
      if (A_W < 1)       begin : g_bad_a   $error("A_W must be at least 1");     end
   endgenerate

   // Frame-boundary shadow of every timing and polarity input
   logic [CFG_W-1:0] cfg_in, cfg_q;
   dtg_pol_t         shd_pol;
   logic [H_W-1:0]   s_h_period, s_h_active;
   logic [HS_W-1:0]  s_h_sync;
   logic [HWT_W-1:0] s_h_wait;
   logic [V_W-1:0]   s_v_period, s_v_wait, s_v_active;
   logic [VS_W-1:0]  s_v_sync;

   assign cfg_in = {cfg_launch_fall, cfg_de_high, cfg_vs_high, cfg_hs_high,
                    cfg_v_active, cfg_v_wait, cfg_v_sync, cfg_v_period,
                    cfg_h_active, cfg_h_wait, cfg_h_sync, cfg_h_period};
   assign {shd_pol, s_v_active, s_v_wait, s_v_sync, s_v_period,
           s_h_active, s_h_wait, s_h_sync, s_h_period} = cfg_q;

   logic scan_on, frame_run, load;
   logic h_last, h_zero, h_sync_act, h_vis;
   logic v_last, v_zero, v_sync_act, v_vis;
   logic [H_W-1:0] h_cnt;
   logic [V_W-1:0] v_cnt;
   logic [A_W-1:0] base_q;

   // Next cycle is position (0,0): entering the first frame or wrapping
   assign load = !scan_on || (h_last && v_last);

   dtg_shadow #(.W(CFG_W)) u_cfg_shd (
      .clk(clk), .rst_n(rst_n), .en(load), .d(cfg_in), .q(cfg_q)
   );

   dtg_shadow #(.W(A_W)) u_base_shd (
      .clk(clk), .rst_n(rst_n), .en(load && sync_en), .d(next_base), .q(base_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scan_on   <= 1'b0;
         frame_run <= 1'b0;
      end else begin
         scan_on <= sync_en;
         if (load)
            frame_run <= run_req && sync_en;
      end
   end

   dtg_axis #(.CNT_W(H_W), .SYNC_W(HS_W), .WAIT_W(HWT_W)) u_h_axis (
      .clk(clk), .rst_n(rst_n), .clr(!sync_en || load), .step(scan_on),
      .period(s_h_period), .sync_len(s_h_sync), .wait_len(s_h_wait),
      .act_len(s_h_active), .cnt(h_cnt), .last(h_last), .at_zero(h_zero),
      .sync_act(h_sync_act), .vis_act(h_vis)
   );

   dtg_axis #(.CNT_W(V_W), .SYNC_W(VS_W), .WAIT_W(V_W)) u_v_axis (
      .clk(clk), .rst_n(rst_n), .clr(!sync_en || load), .step(scan_on && h_last),
      .period(s_v_period), .sync_len(s_v_sync), .wait_len(s_v_wait),
      .act_len(s_v_active), .cnt(v_cnt), .last(v_last), .at_zero(v_zero),
      .sync_act(v_sync_act), .vis_act(v_vis)
   );

   logic hs_act, vs_act, de_act, fs_act;
   assign hs_act  = scan_on && h_sync_act;
   assign vs_act  = scan_on && v_sync_act;
   assign de_act  = scan_on && frame_run && h_vis && v_vis;
   assign fs_act  = scan_on && h_zero && v_zero;
   assign pix_req = de_act;

   dtg_out_stage #(.A_W(A_W), .REG(REG_OUTPUTS)) u_out (
      .clk(clk), .rst_n(rst_n),
      .hs_act(hs_act), .vs_act(vs_act), .de_act(de_act), .fs_act(fs_act),
      .run_act(scan_on && frame_run), .pol(shd_pol), .base_in(base_q),
      .hsync(hsync), .vsync(vsync), .de(de), .frame_start(frame_start),
      .running(running), .launch_fall(launch_fall), .base_out(cur_base)
   );
endmodule

// File: rtl/dtg_checker.sv
module dtg_checker #(
   parameter int A_W = 32,
   parameter int H_W = 18,
   parameter int V_W = 16,
   parameter bit REG = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           pix_req,
   input logic           hsync,
   input logic           vsync,
   input logic           de,
   input logic           frame_start,
   input logic           running,
   input logic           scan_on,
   input logic           pol_hs,
   input logic           pol_vs,
   input logic           pol_de,
   input logic [A_W-1:0] cur_base,
   input logic [H_W-1:0] h_cnt,
   input logic [H_W-1:0] h_per,
   input logic [V_W-1:0] v_cnt,
   input logic [V_W-1:0] v_per
);
   AST_HCOUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_on && h_per != '0) |-> (h_cnt < h_per)); // R2

   AST_VCOUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_on && v_per != '0) |-> (v_cnt < v_per)); // R3

   generate
      if (REG) begin : g_reg_chk
         logic [2:0] pol_q;
         logic hs_on, vs_on, de_on;
         always_ff @(posedge clk) begin
            if (!rst_n) pol_q <= '0;
            else        pol_q <= {pol_de, pol_vs, pol_hs};
         end
         assign hs_on = (hsync == pol_q[0]);
         assign vs_on = (vsync == pol_q[1]);
         assign de_on = (de == pol_q[2]);

         AST_DE_LEADS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
            de_on == $past(pix_req)); // R5

         AST_NO_DE_WITHOUT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            !running |-> !de_on); // R8

         AST_BASE_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
            !frame_start |-> $stable(cur_base)); // R9

         AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(scan_on) |-> (!hs_on && !vs_on && !de_on && !frame_start)); // R12
      end
   endgenerate
endmodule

bind dotclk_timing_gen dtg_checker #(
   .A_W(A_W), .H_W(H_W), .V_W(V_W), .REG(REG_OUTPUTS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pix_req(pix_req), .hsync(hsync), .vsync(vsync),
   .de(de), .frame_start(frame_start), .running(running), .scan_on(scan_on),
   .pol_hs(shd_pol.hs_high), .pol_vs(shd_pol.vs_high), .pol_de(shd_pol.de_high),
   .cur_base(cur_base), .h_cnt(h_cnt), .h_per(s_h_period),
   .v_cnt(v_cnt), .v_per(s_v_period)
);

// File: tb/dotclk_timing_gen_tb.sv
`timescale 1ns/1ps
module dotclk_timing_gen_tb;
   localparam int H_W = 10, HS_W = 6, HWT_W = 8, V_W = 8, VS_W = 10, A_W = 16;

   logic clk = 1'b0, rst_n = 1'b0, sync_en = 1'b0, run_req = 1'b0;
   logic [H_W-1:0]   cfg_h_period = '0, cfg_h_active = '0;
   logic [HS_W-1:0]  cfg_h_sync = '0;
   logic [HWT_W-1:0] cfg_h_wait = '0;
   logic [V_W-1:0]   cfg_v_period = '0, cfg_v_wait = '0, cfg_v_active = '0;
   logic [VS_W-1:0]  cfg_v_sync = '0;
   logic cfg_hs_high = 0, cfg_vs_high = 0, cfg_de_high = 0, cfg_launch_fall = 0;
   logic [A_W-1:0] next_base = '0;
   logic hsync, vsync, de, pix_req, frame_start, running, launch_fall;
   logic [A_W-1:0] cur_base;

   always #2 clk = ~clk;

   dotclk_timing_gen #(.H_W(H_W), .HS_W(HS_W), .HWT_W(HWT_W), .V_W(V_W),
                       .VS_W(VS_W), .A_W(A_W), .REG_OUTPUTS(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .sync_en(sync_en), .run_req(run_req),
      .cfg_h_period(cfg_h_period), .cfg_h_sync(cfg_h_sync), .cfg_h_wait(cfg_h_wait),
      .cfg_h_active(cfg_h_active), .cfg_v_period(cfg_v_period), .cfg_v_sync(cfg_v_sync),
      .cfg_v_wait(cfg_v_wait), .cfg_v_active(cfg_v_active), .cfg_hs_high(cfg_hs_high),
      .cfg_vs_high(cfg_vs_high), .cfg_de_high(cfg_de_high),
      .cfg_launch_fall(cfg_launch_fall), .next_base(next_base),
      .hsync(hsync), .vsync(vsync), .de(de), .pix_req(pix_req),
      .frame_start(frame_start), .running(running), .launch_fall(launch_fall),
      .cur_base(cur_base)
   );

   typedef struct {
      int hp, hs, hw, ha, vp, vs, vw, va;
      bit phs, pvs, pde, fall, run;
      int base;
   } fcfg_t;

   typedef struct {
      bit hs, vs, de, deact, fs, run, fall, pix, pixv;
      int base;
   } item_t;

   item_t q[$];
   fcfg_t fr[2];
   int errors = 0, checks = 0;
   bit mon_go = 0, done = 0;

   task automatic chk(input string tag, input int actual, input int expct);
      checks++;
      if (actual != expct) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expct, $time);
      end
   endtask

   task automatic apply(input fcfg_t c);
      cfg_h_period = H_W'(c.hp);   cfg_h_sync = HS_W'(c.hs);
      cfg_h_wait = HWT_W'(c.hw);   cfg_h_active = H_W'(c.ha);
      cfg_v_period = V_W'(c.vp);   cfg_v_sync = VS_W'(c.vs);
      cfg_v_wait = V_W'(c.vw);     cfg_v_active = V_W'(c.va);
      cfg_hs_high = c.phs; cfg_vs_high = c.pvs; cfg_de_high = c.pde;
      cfg_launch_fall = c.fall; run_req = c.run; next_base = A_W'(c.base);
   endtask

   // Driver side of the scoreboard: expected items from the requirements
   task automatic build(input int n);
      item_t tmp[$];
      item_t it;
      for (int k = 0; k < n; k++)
         for (int v = 0; v < fr[k].vp; v++)
            for (int h = 0; h < fr[k].hp; h++) begin
               bit ha, va, dv;
               ha = h < fr[k].hs;                                   // R2
               va = v < fr[k].vs;                                   // R3
               dv = fr[k].run && h >= fr[k].hw && h < fr[k].hw + fr[k].ha &&
                    v >= fr[k].vw && v < fr[k].vw + fr[k].va;       // R4
               it.hs = fr[k].phs ? ha : !ha;                        // R6
               it.vs = fr[k].pvs ? va : !va;
               it.de = fr[k].pde ? dv : !dv;
               it.deact = dv;
               it.fs = (h == 0 && v == 0);                          // R11
               it.run = fr[k].run;
               it.fall = fr[k].fall;
               it.base = fr[k].base;
               it.pix = 1'b0;
               it.pixv = 1'b0;
               tmp.push_back(it);
            end
      for (int i = 0; i < tmp.size(); i++) begin
         it = tmp[i];
         if (i + 1 < tmp.size()) begin
            it.pix = tmp[i+1].deact;                                // R5
            it.pixv = 1'b1;
         end
         q.push_back(it);
      end
   endtask

   task automatic play(input int n);
      build(n);
      apply(fr[0]);
      @(negedge clk); sync_en = 1'b1;
      @(negedge clk); #1 mon_go = 1'b1;
      for (int k = 0; k < n; k++) begin
         int len;
         len = fr[k].hp * fr[k].vp;
         repeat (len / 2) @(negedge clk);
         if (k + 1 < n) apply(fr[k+1]);                             // R10 mid-frame change
         repeat (len - len / 2) @(negedge clk);
      end
      #1;
      while (q.size() != 0) begin @(negedge clk); #1; end
      mon_go = 1'b0;
      sync_en = 1'b0;
      repeat (4) @(negedge clk);
      // R12: scanning stopped, inactive levels, base held
      chk("R12 hsync idle", hsync, fr[n-1].phs ? 0 : 1);
      chk("R12 vsync idle", vsync, fr[n-1].pvs ? 0 : 1);
      chk("R12 de idle", de, fr[n-1].pde ? 0 : 1);
      chk("R12 frame_start idle", frame_start, 0);
      chk("R12 pix_req idle", pix_req, 0);
      chk("R12 running idle", running, 0);
      chk("R9 base held in idle", cur_base, fr[n-1].base);
   endtask

   // Monitor side of the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (mon_go && q.size() > 0) begin
            item_t e;
            e = q.pop_front();
            chk("R2 R6 R10 hsync", hsync, e.hs);
            chk("R3 R6 R10 vsync", vsync, e.vs);
            chk("R4 R7 R8 de", de, e.de);
            chk("R11 frame_start", frame_start, e.fs);
            chk("R7 R8 running", running, e.run);
            chk("R6 launch_fall", launch_fall, e.fall);
            chk("R9 cur_base", cur_base, e.base);
            if (e.pixv) chk("R5 pix_req", pix_req, e.pix);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog R11 actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state held in reset
      chk("R1 hsync reset", hsync, 1);
      chk("R1 de reset", de, 1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 hsync", hsync, 1);
      chk("R1 vsync", vsync, 1);
      chk("R1 de", de, 1);
      chk("R1 frame_start", frame_start, 0);
      chk("R1 running", running, 0);
      chk("R1 pix_req", pix_req, 0);
      chk("R1 cur_base", cur_base, 0);

      // R7: sync only, active-high polarities
      fr[0] = '{hp:10, hs:2, hw:3, ha:5, vp:6, vs:1, vw:2, va:3,
                phs:1, pvs:1, pde:1, fall:0, run:0, base:'h1111};
      play(1);

      // R9 R10 R6: running frames, polarity/timing/base change mid-frame
      fr[0] = '{hp:8, hs:1, hw:2, ha:4, vp:5, vs:2, vw:2, va:2,
                phs:0, pvs:0, pde:0, fall:0, run:1, base:'h2000};
      fr[1] = '{hp:9, hs:3, hw:4, ha:3, vp:4, vs:1, vw:1, va:2,
                phs:1, pvs:0, pde:1, fall:1, run:1, base:'h2040};
      play(2);

      // R8 R4: zero wait with full-line window, run cleared mid-frame
      fr[0] = '{hp:6, hs:2, hw:0, ha:6, vp:4, vs:1, vw:0, va:4,
                phs:0, pvs:1, pde:1, fall:0, run:1, base:'h3000};
      fr[1] = '{hp:6, hs:2, hw:0, ha:6, vp:4, vs:1, vw:0, va:4,
                phs:0, pvs:1, pde:1, fall:0, run:0, base:'h3000};
      play(2);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule